// File: doc/BRIEF.md
# Periodic Reload Timer with Acknowledge

This block is a down-counting interval timer that produces a periodic, level-sensitive interrupt request. It advances by one count on each cycle in which an external tick enable is high; the tick stands in for a fixed reference clock, and one count equals one reference period. Software programs a reload value, an interrupt enable and a run enable through one control word on a 32-bit register bus. When the count runs out, the timer raises an interrupt flag that sits inside that same control word and restarts the count by itself.

A second, write-only register acknowledges the timer. One of its bits clears the flag. Another bit restarts the countdown from the programmed reload value, but only while the timer runs. The interrupt request is asserted while both the flag and the interrupt enable are set. It goes to a separate interrupt router, which decides which processor receives it.

Top module: `periodic_tick_timer`

## Requirements
- R1: A read at offset 0x34 returns the control word: the interrupt flag in bit 31, and bits 30:0 exactly as last written (bit 30 reload request, bit 29 interrupt enable, bit 28 run enable, bits 27:0 reload value).
- R2: A read at the acknowledge offset 0x38 returns zero, and so does a read at any other offset that is not 0x34.
- R3: A write at 0x34 with bit 28 set loads the count from bits 27:0 of the written data. With reload value N, the flag sets on the Nth tick after that write and on no earlier tick.
- R4: On expiry the flag is set and the count is reloaded, so the flag sets again exactly N ticks later.
- R5: A write at 0x38 with bit 31 set clears the flag.
- R6: The interrupt request output is high exactly when the flag and bit 29 are both set. With bit 29 clear, the flag still sets and is readable, but the request stays low.
- R7: A write at 0x38 with bit 30 set while the timer runs restarts the count from the stored reload value.
- R8: Reset clears the whole control word, including the flag, and stops the counter.
- R9: A write at 0x34 with bit 28 clear stops the counter. While the timer is stopped, ticks and acknowledge restarts cause no expiry.
- R10: With a reload value of zero the timer never expires, however many ticks arrive.
- R11: If an expiry and an acknowledge clear fall in the same cycle, the flag ends up set.
- R12: A write at 0x34 leaves the flag unchanged: bit 31 of the written data neither sets nor clears it.
- R13: The count moves only in cycles with the tick enable high. Idle cycles neither advance it nor cause an expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Reference tick; one count per high cycle |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| irq | output | 1 | Level interrupt request to the router |

## Verification
Two functions can meet in one cycle: an expiry, in which the last tick of a period reaches the count, and an acknowledge write that clears the flag. The bench provokes this by counting the timer down to its last count and then raising the tick in the same cycle as the acknowledge strobe. This is done once with the flag already clear and once with it already set. In both cases the flag and the request must read as set afterwards.

// File: rtl/ptt_pkg.sv
`timescale 1ns/1ps
package ptt_pkg;
   // control word field positions (software decodes these)
   localparam int unsigned FLAG_BIT   = 31;
   localparam int unsigned RLDREQ_BIT = 30;
   localparam int unsigned IRQEN_BIT  = 29;
   localparam int unsigned RUNEN_BIT  = 28;
   localparam int unsigned VALUE_MAX  = 28;

   typedef struct packed {
      logic ctrl_wr;
      logic ack_wr;
   } ptt_strobe_t;
endpackage

// File: rtl/ptt_ctrl_regs.sv
`timescale 1ns/1ps
module ptt_ctrl_regs
   import ptt_pkg::*;
#(
   parameter int unsigned          DATA_W   = 32,
   parameter int unsigned          ADDR_W   = 8,
   parameter int unsigned          CNT_W    = 28,
   parameter logic [ADDR_W-1:0]    CTRL_OFS = 'h34,
   parameter logic [ADDR_W-1:0]    ACK_OFS  = 'h38,
   parameter bit                   SYNC_RD  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              flag,
   output ptt_strobe_t       strobe,
   output logic              irq_en,
   output logic              run,
   output logic              load,
   output logic [CNT_W-1:0]  load_val,
   output logic [CNT_W-1:0]  reload_val,
   output logic              ack_clr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned STORE_W = DATA_W - 1;

   logic [STORE_W-1:0] ctrl_q;
   logic               hit_ctrl;
   logic               hit_ack;
   logic [DATA_W-1:0]  rd_word;
   logic               run_en;

   assign hit_ctrl       = bus_sel && (bus_addr == CTRL_OFS);
   assign hit_ack        = bus_sel && (bus_addr == ACK_OFS);
   assign strobe.ctrl_wr = hit_ctrl && bus_wr;
   assign strobe.ack_wr  = hit_ack && bus_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (strobe.ctrl_wr) begin
         ctrl_q <= bus_wdata[STORE_W-1:0];
      end
   end

   assign irq_en     = ctrl_q[IRQEN_BIT];
   assign run_en     = ctrl_q[RUNEN_BIT];
   assign reload_val = ctrl_q[CNT_W-1:0];
   assign run        = run_en && (reload_val != '0);

   // fresh start from written value, or restart from stored value when running
   assign load     = (strobe.ctrl_wr && bus_wdata[RUNEN_BIT]) ||
                     (strobe.ack_wr && bus_wdata[RLDREQ_BIT] && run_en);
   assign load_val = strobe.ctrl_wr ? bus_wdata[CNT_W-1:0] : reload_val;
   assign ack_clr  = strobe.ack_wr && bus_wdata[FLAG_BIT];

   always_comb begin
      rd_word = '0;
      if (hit_ctrl && !bus_wr) begin
         rd_word = {flag, ctrl_q};
      end
   end

   generate
      if (SYNC_RD) begin : g_rd_sync
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_word;
         end
         assign rd_data = rd_q;
      end else begin : g_rd_comb
         assign rd_data = rd_word;
      end
   endgenerate
endmodule

// File: rtl/ptt_down_counter.sv
`timescale 1ns/1ps
module ptt_down_counter #(
   parameter int unsigned CNT_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             load,
   input  logic             hold_off,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   output logic             expire,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   logic [CNT_W-1:0] count_q;

   // a control write in the same cycle takes precedence over the last tick
   assign expire = run && tick && (count_q == LAST) && !hold_off;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (load) begin
         count_q <= load_val;
      end else if (expire) begin
         count_q <= reload_val;
      end else if (run && tick && (count_q != '0)) begin
         count_q <= count_q - LAST;
      end
   end

   assign count = count_q;
endmodule

// File: rtl/ptt_irq_flag.sv
`timescale 1ns/1ps
module ptt_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic clr,
   input  logic irq_en,
   output logic flag,
   output logic irq
);
   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (expire) begin
         flag_q <= 1'b1;
      end else if (clr) begin
         flag_q <= 1'b0;
      end
   end

   assign flag = flag_q;
   assign irq  = flag_q && irq_en;
endmodule

// File: rtl/periodic_tick_timer.sv
`timescale 1ns/1ps
module periodic_tick_timer
   import ptt_pkg::*;
#(
   parameter int unsigned       DATA_W   = 32,
   parameter int unsigned       ADDR_W   = 8,
   parameter int unsigned       CNT_W    = 28,
   parameter logic [ADDR_W-1:0] CTRL_OFS = 'h34,
   parameter logic [ADDR_W-1:0] ACK_OFS  = 'h38,
   parameter bit                SYNC_RD  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("periodic_tick_timer: DATA_W must be 32");
      end
      if ((CNT_W < 2) || (CNT_W > VALUE_MAX)) begin : g_bad_cnt_w
         $error("periodic_tick_timer: CNT_W out of range");
      end
      if ((CTRL_OFS[1:0] != 2'b00) || (ACK_OFS[1:0] != 2'b00) || (CTRL_OFS == ACK_OFS)) begin : g_bad_ofs
         $error("periodic_tick_timer: offsets must be distinct and word aligned");
      end
   endgenerate

   ptt_strobe_t      strobe;
   logic             irq_en;
   logic             run;
   logic             load;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] reload_val;
   logic             ack_clr;
   logic             expire;
   logic [CNT_W-1:0] count;
   logic             flag;
   logic             ctrl_wr;

   assign ctrl_wr = strobe.ctrl_wr;

   ptt_ctrl_regs #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .CNT_W   (CNT_W),
      .CTRL_OFS(CTRL_OFS),
      .ACK_OFS (ACK_OFS),
      .SYNC_RD (SYNC_RD)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .flag      (flag),
      .strobe    (strobe),
      .irq_en    (irq_en),
      .run       (run),
      .load      (load),
      .load_val  (load_val),
      .reload_val(reload_val),
      .ack_clr   (ack_clr),
      .rd_data   (bus_rdata)
   );

   ptt_down_counter #(
      .CNT_W(CNT_W)
   ) cnt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_en),
      .run       (run),
      .load      (load),
      .hold_off  (ctrl_wr),
      .load_val  (load_val),
      .reload_val(reload_val),
      .expire    (expire),
      .count     (count)
   );

   ptt_irq_flag flag_i (
      .clk   (clk),
      .rst_n (rst_n),
      .expire(expire),
      .clr   (ack_clr),
      .irq_en(irq_en),
      .flag  (flag),
      .irq   (irq)
   );
endmodule

// File: rtl/periodic_tick_timer_chk.sv
`timescale 1ns/1ps
module periodic_tick_timer_chk #(
   parameter int unsigned       DATA_W   = 32,
   parameter int unsigned       ADDR_W   = 8,
   parameter int unsigned       CNT_W    = 28,
   parameter logic [ADDR_W-1:0] ACK_OFS  = 'h38,
   parameter bit                SYNC_RD  = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              expire,
   input logic              flag,
   input logic              irq_en,
   input logic              irq,
   input logic              run,
   input logic              load,
   input logic              ctrl_wr,
   input logic              ack_clr,
   input logic [CNT_W-1:0]  count,
   input logic [CNT_W-1:0]  reload_val
);
   assert_expire_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> flag);

   assert_expire_reloads_R4: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (count == $past(reload_val)));

   assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_clr && !expire) |=> !flag);

   assert_irq_raised_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && irq_en) |-> irq);

   assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag || !irq_en) |-> !irq);

   assert_stopped_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(count));

   assert_zero_reload_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_val == '0) |-> !expire);

   assert_expiry_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && ack_clr) |=> flag);

   assert_ctrl_keeps_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !expire) |=> (flag == $past(flag)));

   generate
      if (!SYNC_RD) begin : g_comb_rd
         assert_ack_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && !bus_wr && (bus_addr == ACK_OFS)) |-> (bus_rdata == '0));
      end
   endgenerate
endmodule

bind periodic_tick_timer periodic_tick_timer_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W),
   .ACK_OFS(ACK_OFS),
   .SYNC_RD(SYNC_RD)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .expire    (expire),
   .flag      (flag),
   .irq_en    (irq_en),
   .irq       (irq),
   .run       (run),
   .load      (load),
   .ctrl_wr   (ctrl_wr),
   .ack_clr   (ack_clr),
   .count     (count),
   .reload_val(reload_val)
);

// File: tb/periodic_tick_timer_tb_top.sv
`timescale 1ns/1ps
module periodic_tick_timer_tb_top;
   localparam logic [7:0] CTRL_A = 8'h34;
   localparam logic [7:0] ACK_A  = 8'h38;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int unsigned n_checks = 0;
   int unsigned n_errors = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   periodic_tick_timer dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .irq      (irq)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick_en = 1'b1;
      end
      @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic check_irq(string req, logic exp);
      #1 check(req, {31'd0, irq}, {31'd0, exp});
   endtask

   task automatic check_ctrl(string req, logic [31:0] exp);
      logic [31:0] v;
      bus_read(CTRL_A, v);
      check(req, v, exp);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      do_reset();
      check_irq("R8 irq after reset", 1'b0);
      check_ctrl("R8 control after reset", 32'h0);
      bus_read(ACK_A, v);
      check("R2 ack reads zero", v, 32'h0);
      bus_read(8'h40, v);
      check("R2 unmapped reads zero", v, 32'h0);
   endtask

   task automatic t_period();
      bus_write(CTRL_A, 32'h3000_0005);
      check_ctrl("R1 readback", 32'h3000_0005);
      ticks(4);
      check_irq("R3 no expiry before N ticks", 1'b0);
      ticks(1);
      check_irq("R3 expiry at N ticks", 1'b1);
      check_ctrl("R1 flag in bit 31", 32'hB000_0005);
   endtask

   task automatic t_autoreload();
      logic [31:0] v;
      bus_write(ACK_A, 32'h8000_0000);
      check_ctrl("R5 ack clears flag", 32'h3000_0005);
      check_irq("R5 irq low after clear", 1'b0);
      bus_read(ACK_A, v);
      check("R2 ack reads zero with timer active", v, 32'h0);
      ticks(4);
      check_irq("R4 no early re-expiry", 1'b0);
      ticks(1);
      check_irq("R4 periodic re-expiry", 1'b1);
   endtask

   task automatic t_gate();
      bus_write(CTRL_A, 32'h1000_0005);
      check_ctrl("R12 control write keeps flag set", 32'h9000_0005);
      check_irq("R6 irq masked by enable", 1'b0);
      bus_write(ACK_A, 32'h8000_0000);
      bus_write(CTRL_A, 32'h9000_0003);
      check_ctrl("R12 written bit 31 does not set flag", 32'h1000_0003);
      ticks(3);
      check_ctrl("R6 flag sets with irq disabled", 32'h9000_0003);
      check_irq("R6 irq stays low", 1'b0);
      bus_write(ACK_A, 32'h8000_0000);
   endtask

   task automatic t_restart();
      bus_write(CTRL_A, 32'h3000_0006);
      ticks(3);
      repeat (20) @(negedge clk);
      check_irq("R13 idle cycles do not count", 1'b0);
      bus_write(ACK_A, 32'h4000_0000);
      ticks(5);
      check_irq("R7 restart pushed expiry out", 1'b0);
      ticks(1);
      check_irq("R7 expiry N ticks after restart", 1'b1);
      check_ctrl("R7 restart leaves control bits", 32'hB000_0006);
      bus_write(ACK_A, 32'h8000_0000);
   endtask

   task automatic t_stop();
      bus_write(CTRL_A, 32'h3000_0004);
      ticks(2);
      bus_write(CTRL_A, 32'h2000_0004);
      ticks(10);
      check_irq("R9 stopped timer does not expire", 1'b0);
      bus_write(ACK_A, 32'h4000_0000);
      ticks(10);
      check_irq("R9 restart ignored while stopped", 1'b0);
      check_ctrl("R9 control shows stopped", 32'h2000_0004);
   endtask

   task automatic t_zero();
      bus_write(CTRL_A, 32'h3000_0000);
      ticks(100);
      check_irq("R10 zero reload never expires", 1'b0);
      check_ctrl("R10 flag clear", 32'h3000_0000);
   endtask

   task automatic collide_ack();
      @(negedge clk);
      tick_en = 1'b1;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ACK_A; bus_wdata = 32'h8000_0000;
      @(negedge clk);
      tick_en = 1'b0;
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic t_collide();
      bus_write(CTRL_A, 32'h3000_0003);
      ticks(2);
      collide_ack();
      check_irq("R11 expiry wins over clear (flag was clear)", 1'b1);
      ticks(2);
      collide_ack();
      check_irq("R11 expiry wins over clear (flag was set)", 1'b1);
      check_ctrl("R11 flag readable", 32'hB000_0003);
   endtask

   task automatic t_reset_mid();
      do_reset();
      check_irq("R8 reset drops irq", 1'b0);
      check_ctrl("R8 reset clears control", 32'h0);
      ticks(10);
      check_irq("R8 counter stopped after reset", 1'b0);
   endtask

   initial begin
      t_reset();
      t_period();
      t_autoreload();
      t_gate();
      t_restart();
      t_stop();
      t_zero();
      t_collide();
      t_reset_mid();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule